// File: doc/BRIEF.md
# Synchronous Memory Read Output Stage

This block forms the read-data output path of a synchronous static memory. Each rising clock edge samples a command (read, write or deselect) into an input register. An external array, outside this block, then presents the read word on `arr_rdata` during the cycle after that edge. The block sends the word to `dout` and raises `dout_vld` whenever the output drivers would be on. A static mode input selects one of two paths. With `bypass_en` high, the word goes straight to the output (flow-through). With `bypass_en` low, the word passes through a rising-edge output register and appears one cycle later (pipelined). Tying the pin low gives pipelined operation.

Deselect and write commands travel through the same number of stages as reads. In pipelined mode the drivers therefore stay on for one full cycle after a deselect or write is sampled, and go off only after the second rising edge. The active-low output enable `oe_n` is asynchronous. It gates `dout_vld` at once, with no clock edge. Whenever `dout_vld` is low, `dout` is held at all zeros.

The output is a valid-only stream. `dout_vld` marks each beat, there is no ready input, and the block cannot be back-pressured: a beat that the consumer does not take is lost. Back-to-back reads produce one beat per cycle.

Top module: `srout_top`

## Requirements
- R1: `cmd_i` is sampled on every rising edge of `clk`, with this encoding: 2'b00 deselect, 2'b01 read, 2'b10 write. The code 2'b11 is handled exactly as a deselect.
- R2: With `bypass_en`=1, a read sampled at edge k drives `dout_vld`=1 during the cycle after edge k, and `dout` follows `arr_rdata` combinationally in that cycle.
- R3: With `bypass_en`=0, a read sampled at edge k causes the `arr_rdata` value present at edge k+1 to be registered there and shown on `dout`, with `dout_vld`=1, during the cycle after edge k+1.
- R4: `oe_n` is active low and asynchronous. When it rises, `dout_vld` falls within the same cycle. When it falls, `dout_vld` rises within the same cycle if the drive state is on.
- R5: A deselect is delayed exactly as a read is. With `bypass_en`=0, a deselect sampled at edge k leaves the previous read's beat on until edge k+1 and turns the drivers off after edge k+1. With `bypass_en`=1, the drivers turn off after edge k.
- R6: A sampled write turns the drivers off with the same delay as a deselect in both modes.
- R7: Whenever `dout_vld` is 0, `dout` is all zeros.
- R8: An asynchronous active-low `rst_n` clears both command stages to deselect and clears the output register to zero, so `dout_vld`=0 and `dout`=0.
- R9: With `bypass_en`=0, a beat on `dout` does not change when `arr_rdata` changes between clock edges.
- R10: Back-to-back reads produce a new beat every cycle in both modes, each beat equal to the array word of its own read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | Static mode: 1 selects flow-through, 0 selects pipelined |
| cmd_i | input | 2 | Per-cycle command: 00 deselect, 01 read, 10 write, 11 deselect |
| arr_rdata | input | DW (36) | Array read word for the command sampled at the previous edge |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | DW (36) | Output data, zero when not valid |
| dout_vld | output | 1 | High when the output drivers would be on |

## Verification
Two things can happen in the same cycle: the clocked, delayed turn-off after a deselect or write, and an asynchronous change of `oe_n`. The bench toggles `oe_n` between edges while a beat is on, and also around the edge where a pipelined deselect takes effect. Between edges it checks `dout_vld` and `dout` against a model that combines the delayed drive state with the live enable. The bench also changes `arr_rdata` in the middle of the cycle. This shows that the registered path holds its beat while the bypass path follows the new word.

// File: rtl/srout_pkg.sv
package srout_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  // Reserved code folds onto deselect.
  function automatic logic [1:0] cmd_norm(input logic [1:0] c);
    return (c == CMD_RSVD) ? CMD_DESEL : c;
  endfunction

endpackage

// File: rtl/srout_cmd_stage.sv
module srout_cmd_stage
  import srout_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd_i,
  output logic [1:0] cmd_s1,
  output logic       rd_s1
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_s1 <= CMD_DESEL;
    else        cmd_s1 <= cmd_norm(cmd_i);
  end

  assign rd_s1 = (cmd_s1 == CMD_READ);

  // R1
  rsvd_as_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) == CMD_RSVD) |-> !rd_s1);

  // R1
  read_sampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) == CMD_READ) |-> rd_s1);

endmodule

// File: rtl/srout_drive_pipe.sv
module srout_drive_pipe #(
  parameter int EXTRA_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass_en,
  input  logic rd_s1,
  output logic drive
);

  localparam int NS = (EXTRA_STAGES < 1) ? 1 : EXTRA_STAGES;

  logic [NS-1:0] drv_q;

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) drv_q[0] <= 1'b0;
          else        drv_q[0] <= rd_s1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) drv_q[g] <= 1'b0;
          else        drv_q[g] <= drv_q[g-1];
        end
      end
    end
  endgenerate

  assign drive = bypass_en ? rd_s1 : drv_q[NS-1];

  // R5
  desel_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && $past(!rd_s1)) |-> !drive);

endmodule

// File: rtl/srout_data_reg.sv
module srout_data_reg #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R9
  hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!load) |-> $stable(q));

endmodule

// File: rtl/srout_top.sv
module srout_top
  import srout_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass_en,
  input  logic [1:0]    cmd_i,
  input  logic [DW-1:0] arr_rdata,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);

  localparam logic [DW-1:0] IDLE_WORD = '0;

  logic [1:0]    cmd_s1;
  logic          rd_s1;
  logic          drive;
  logic [DW-1:0] pipe_q;
  logic [DW-1:0] sel_data;

  srout_cmd_stage u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd_i),
    .cmd_s1 (cmd_s1),
    .rd_s1  (rd_s1)
  );

  srout_drive_pipe #(.EXTRA_STAGES(1)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .bypass_en (bypass_en),
    .rd_s1     (rd_s1),
    .drive     (drive)
  );

  srout_data_reg #(.DW(DW)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_s1),
    .d     (arr_rdata),
    .q     (pipe_q)
  );

  assign sel_data = bypass_en ? arr_rdata : pipe_q;
  assign dout_vld = drive & ~oe_n;
  assign dout     = dout_vld ? sel_data : IDLE_WORD;

  // R2
  flow_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && dout_vld) |-> ($past(cmd_i) == CMD_READ));

  // R3
  pipe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && $stable(bypass_en) && dout_vld) |-> (dout == $past(arr_rdata)));

  // R5
  pipe_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && $stable(bypass_en) && dout_vld) |-> ($past(cmd_i, 2) == CMD_READ));

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_vld);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == IDLE_WORD));

endmodule

// File: tb/srout_top_tb.sv
`timescale 1ns/100ps
module srout_top_tb;

  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bypass_en = 1'b0;
  logic [1:0]    cmd_i = 2'b00;
  logic [DW-1:0] arr_rdata = '0;
  logic          oe_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_vld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [1:0]    m_s1, m_s2;
  logic [DW-1:0] m_pq;

  always #2.5 clk = ~clk;

  srout_top #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .cmd_i(cmd_i),
    .arr_rdata(arr_rdata), .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic [1:0] norm(input logic [1:0] c);
    return (c == 2'b11) ? 2'b00 : c;
  endfunction

  function automatic logic exp_vld();
    logic drv;
    drv = bypass_en ? (m_s1 == 2'b01) : (m_s2 == 2'b01);
    return drv & ~oe_n;
  endfunction

  function automatic logic [DW-1:0] exp_dout();
    if (!exp_vld()) return '0;
    return bypass_en ? arr_rdata : m_pq;
  endfunction

  task automatic check(input string tag);
    logic          ev;
    logic [DW-1:0] ed;
    ev = exp_vld();
    ed = exp_dout();
    n_run++;
    if (dout_vld !== ev) begin
      n_fail++;
      $display("FAIL %s dout_vld actual=%0b expected=%0b", tag, dout_vld, ev);
    end
    n_run++;
    if (dout !== ed) begin
      n_fail++;
      $display("FAIL %s dout actual=%h expected=%h", tag, dout, ed);
    end
  endtask

  task automatic model_edge();
    if (m_s1 == 2'b01) m_pq = arr_rdata;
    m_s2 = m_s1;
    m_s1 = norm(cmd_i);
  endtask

  // Drive at falling edge, check mid-low-phase, then advance one edge.
  task automatic step(input logic [1:0] c, input logic [DW-1:0] d,
                      input logic oe, input string tag);
    @(negedge clk);
    cmd_i = c; arr_rdata = d; oe_n = oe;
    #0.5 check(tag);
  endtask

  task automatic edge_adv();
    @(posedge clk);
    model_edge();
  endtask

  task automatic mid(input logic [DW-1:0] d, input logic oe, input string tag);
    arr_rdata = d; oe_n = oe;
    #0.5 check(tag);
  endtask

  task automatic do_reset(input logic byp);
    @(negedge clk);
    rst_n = 1'b0; bypass_en = byp; cmd_i = 2'b00; oe_n = 1'b0;
    arr_rdata = 36'hFFFFFFFFF;
    m_s1 = 2'b00; m_s2 = 2'b00; m_pq = '0;
    #0.5 check("R8 reset");
    @(negedge clk);
    rst_n = 1'b1;
    edge_adv();
  endtask

  task automatic directed(input string md);
    // R10 burst of reads then R5 deselect
    step(2'b01, 36'h111111111, 1'b0, {"R10 ", md}); edge_adv();
    step(2'b01, 36'h222222222, 1'b0, {"R2/R3 ", md}); edge_adv();
    step(2'b01, 36'h333333333, 1'b0, {"R10 ", md}); edge_adv();
    step(2'b00, 36'h444444444, 1'b0, {"R5 ", md}); edge_adv();
    step(2'b00, 36'h555555555, 1'b0, {"R5 ", md}); edge_adv();
    step(2'b00, 36'h666666666, 1'b0, {"R5 ", md}); edge_adv();
    // R6 read then write
    step(2'b01, 36'h0A0A0A0A0, 1'b0, {"R6 ", md}); edge_adv();
    step(2'b10, 36'h0B0B0B0B0, 1'b0, {"R6 ", md}); edge_adv();
    step(2'b10, 36'h0C0C0C0C0, 1'b0, {"R6 ", md}); edge_adv();
    step(2'b00, 36'h0D0D0D0D0, 1'b0, {"R6 ", md}); edge_adv();
    // R1 reserved code acts as deselect
    step(2'b01, 36'h123456789, 1'b0, {"R1 ", md}); edge_adv();
    step(2'b11, 36'h987654321, 1'b0, {"R1 ", md}); edge_adv();
    step(2'b11, 36'h13579BDF0, 1'b0, {"R1 ", md}); edge_adv();
    step(2'b00, 36'h2468ACE02, 1'b0, {"R1 ", md}); edge_adv();
    // R4 / R9 mid-cycle changes while a beat is on
    step(2'b01, 36'hCAFE00001, 1'b0, {"R4 ", md}); edge_adv();
    step(2'b01, 36'hCAFE00002, 1'b0, {"R4 ", md});
    mid(36'hBEEF00003, 1'b0, {"R9 ", md});
    mid(36'hBEEF00003, 1'b1, {"R4 ", md});
    mid(36'hBEEF00004, 1'b0, {"R4 ", md});
    edge_adv();
    // deselect taking effect while oe toggles around it
    step(2'b00, 36'hBEEF00005, 1'b1, {"R4/R5 ", md});
    mid(36'hBEEF00006, 1'b0, {"R4/R5 ", md});
    mid(36'hBEEF00007, 1'b0, {"R9 ", md});
    edge_adv();
    step(2'b00, 36'hBEEF00008, 1'b0, {"R5 ", md});
    mid(36'hBEEF00009, 1'b1, {"R4 ", md});
    mid(36'hBEEF0000A, 1'b0, {"R7 ", md});
    edge_adv();
  endtask

  task automatic random_run(input int n, input string md);
    for (int i = 0; i < n; i++) begin
      logic [1:0]    c;
      logic [DW-1:0] d;
      logic          oe;
      c  = 2'($urandom_range(0, 3));
      d  = {4'($urandom), 32'($urandom)};
      oe = ($urandom_range(0, 7) == 0);
      step(c, d, oe, {"R10 rand ", md});
      if ($urandom_range(0, 3) == 0)
        mid({4'($urandom), 32'($urandom)}, ($urandom_range(0, 5) == 0), {"R9/R7 rand ", md});
      edge_adv();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_s1 = 2'b00; m_s2 = 2'b00; m_pq = '0;
    do_reset(1'b0);
    directed("pipe");
    random_run(400, "pipe");
    do_reset(1'b1);
    directed("flow");
    random_run(400, "flow");
    do_reset(1'b0);
    random_run(100, "pipe2");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule